// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings one or two SDRAM devices from power-on to a usable state without software involvement. After a single-cycle start pulse it captures which of the two banks are enabled and initializes them one after another, lowest index first. For every bank it sends, in order, a clock-enable command, a precharge-all command, an auto-refresh command that asks for eight refresh cycles, a mode-register load carrying the bank's CAS latency, and a return-to-normal command. It then writes that bank's refresh count, doubled, into the refresh timer.

Each command is presented for one cycle to a downstream command issuer, which reports activity through a busy flag. After each command the sequencer waits a minimum time, counted in clock cycles from a clocks-per-microsecond parameter, and then polls busy until it is low before it moves on. A global controller-enable output is dropped when the sequence starts and raised only after every enabled bank is finished, one cycle after a one-cycle done pulse.

Top module: `sdinit_seq`

## Requirements
- R1: While reset is applied, and after it is released until a start pulse, `ctrl_en`, `done`, `cmd_valid` and `rtimer_wr` are all low.
- R2: A start pulse seen while idle samples `bank_en` and drops `ctrl_en` in the next cycle; `ctrl_en` stays low while commands are issued, and a start pulse or a change of `bank_en` during a run has no effect on that run.
- R3: Only enabled banks are initialized, bank 0 before bank 1; `cmd_target` is one-hot with bit 0 selecting bank 0 and bit 1 selecting bank 1.
- R4: For each bank the `cmd_mode` codes come in the order 1 (clock enable), 2 (precharge all), 3 (auto-refresh), 4 (mode-register load), 0 (normal), with `cmd_valid` high for exactly one cycle per command.
- R5: More than `LONG_US*CLK_PER_US` cycles separate the clock-enable command from the next command, and more than `SHORT_US*CLK_PER_US` cycles separate each precharge, auto-refresh and mode-load command from the next command.
- R6: A command or a refresh-timer write is issued only after busy has been seen low following the previous command's wait; given an issuer whose busy rises only after a command, `cmd_busy` is low in every cycle with `cmd_valid` or `rtimer_wr` high.
- R7: The auto-refresh command carries `cmd_repeat` = 7; every other command carries 0.
- R8: The mode-load command carries `cmd_payload` with bits 3:0 = 0 (burst code), bits 4 upward holding the target bank's CAS latency from `cas_lat` (bank b at bits b*CAS_W upward), and the remaining bits 0; all other commands carry a zero payload.
- R9: After the normal-mode command of a bank and busy low, `rtimer_wr` is high for one cycle with `rtimer_data` equal to that bank's refresh count (bank b at bits b*REF_W of `refresh_cnt`) shifted left by one, before any command for the next bank.
- R10: After the last bank's timer write, `done` is high for one cycle with `ctrl_en` still low; `ctrl_en` is high from the next cycle and stays high until the next start.
- R11: With no bank enabled, no command is issued and `done` is high in the second cycle after the cycle in which start is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for the initialization sequence |
| bank_en | input | 2 | Per-bank enable, bit b for bank b |
| cas_lat | input | 2*CAS_W | CAS latency per bank |
| refresh_cnt | input | 2*REF_W | Refresh count per bank |
| cmd_busy | input | 1 | Command issuer busy flag |
| cmd_valid | output | 1 | Command word valid for one cycle |
| cmd_mode | output | 3 | Command code |
| cmd_target | output | 2 | One-hot target bank |
| cmd_repeat | output | REP_W | Repeat request for auto-refresh |
| cmd_payload | output | PAY_W | Mode-register value |
| rtimer_wr | output | 1 | Refresh-timer write strobe |
| rtimer_data | output | REF_W+1 | Refresh-timer write value |
| ctrl_en | output | 1 | Global controller enable |
| done | output | 1 | Sequence complete pulse |

## Verification
The hardest situation to reach is a busy flag that outlasts the minimum wait, since only then does the poll, rather than the timer, decide when the next command goes out. The bench drives a busy model whose hold time is swept over zero, a few cycles and a value longer than the short wait, across all four bank-enable patterns, so both the timer-bound and the busy-bound paths are exercised for each step. A run with a second start pulse and a flipped bank-enable mask in the middle of a sequence shows that the captured configuration is kept.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  localparam int NUM_BANKS = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PICK  = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_POLL  = 3'd4,
    ST_RTMR  = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_t;

  typedef enum logic [2:0] {
    STEP_CLKON = 3'd0,
    STEP_PRECH = 3'd1,
    STEP_AREF  = 3'd2,
    STEP_MLOAD = 3'd3,
    STEP_NORM  = 3'd4
  } step_t;

  // Command codes decoded by the downstream issuer
  localparam logic [2:0] MODE_NORMAL = 3'd0;
  localparam logic [2:0] MODE_CLKON  = 3'd1;
  localparam logic [2:0] MODE_PRECH  = 3'd2;
  localparam logic [2:0] MODE_AREF   = 3'd3;
  localparam logic [2:0] MODE_MLOAD  = 3'd4;

endpackage

// File: rtl/sdinit_timer.sv
module sdinit_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdinit_bank_pick.sv
module sdinit_bank_pick #(
  parameter  int NB = 2,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [NB-1:0] pend,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [NB-1:0] pend_next
);

  // Lowest pending index wins: scan downward so the last hit is the lowest
  always_comb begin
    idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx = IW'(i);
      end
    end
    any       = |pend;
    pend_next = pend & ~(NB'(1) << idx);
  end

endmodule

// File: rtl/sdinit_cmd_fmt.sv
module sdinit_cmd_fmt
  import sdinit_pkg::*;
#(
  parameter int CAS_W     = 2,
  parameter int PAY_W     = 13,
  parameter int REP_W     = 4,
  parameter int WAIT_W    = 16,
  parameter int LONG_CYC  = 200,
  parameter int SHORT_CYC = 100
) (
  input  step_t              step,
  input  logic [CAS_W-1:0]   cas,
  output logic [2:0]         mode,
  output logic [REP_W-1:0]   rep,
  output logic [PAY_W-1:0]   payload,
  output logic [WAIT_W-1:0]  wait_cyc
);

  localparam int BURST_CODE  = 0;
  localparam int CAS_POS     = 4;
  localparam int AREF_REPEAT = 7;

  always_comb begin
    mode     = MODE_NORMAL;
    rep      = '0;
    payload  = '0;
    wait_cyc = '0;
    case (step)
      STEP_CLKON: begin
        mode     = MODE_CLKON;
        wait_cyc = WAIT_W'(LONG_CYC);
      end
      STEP_PRECH: begin
        mode     = MODE_PRECH;
        wait_cyc = WAIT_W'(SHORT_CYC);
      end
      STEP_AREF: begin
        mode     = MODE_AREF;
        rep      = REP_W'(AREF_REPEAT);
        wait_cyc = WAIT_W'(SHORT_CYC);
      end
      STEP_MLOAD: begin
        mode     = MODE_MLOAD;
        payload  = (PAY_W'(cas) << CAS_POS) | PAY_W'(BURST_CODE);
        wait_cyc = WAIT_W'(SHORT_CYC);
      end
      default: begin
        mode     = MODE_NORMAL;
        wait_cyc = '0;
      end
    endcase
  end

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int LONG_US    = 200,
  parameter int SHORT_US   = 100,
  parameter int CAS_W      = 2,
  parameter int REF_W      = 14,
  parameter int PAY_W      = 13,
  parameter int REP_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              bank_en,
  input  logic [2*CAS_W-1:0]      cas_lat,
  input  logic [2*REF_W-1:0]      refresh_cnt,
  input  logic                    cmd_busy,
  output logic                    cmd_valid,
  output logic [2:0]              cmd_mode,
  output logic [1:0]              cmd_target,
  output logic [REP_W-1:0]        cmd_repeat,
  output logic [PAY_W-1:0]        cmd_payload,
  output logic                    rtimer_wr,
  output logic [REF_W:0]          rtimer_data,
  output logic                    ctrl_en,
  output logic                    done
);

  localparam int NB        = NUM_BANKS;
  localparam int IW        = (NB > 1) ? $clog2(NB) : 1;
  localparam int LONG_CYC  = CLK_PER_US * LONG_US;
  localparam int SHORT_CYC = CLK_PER_US * SHORT_US;
  localparam int WAIT_W    = $clog2(LONG_CYC + 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i_n = rst_sync_q[1];

  // State
  seq_state_t     state_q, state_d;
  step_t          step_q, step_d;
  logic [IW-1:0]  bank_q, bank_d;
  logic [NB-1:0]  pend_q, pend_d;
  logic           en_q, en_d;

  // Helpers
  logic               pick_any;
  logic [IW-1:0]      pick_idx;
  logic [NB-1:0]      pick_next;
  logic               tmr_load;
  logic               tmr_tick;
  logic               tmr_zero;
  logic [WAIT_W-1:0]  fmt_wait;
  logic [2:0]         fmt_mode;
  logic [REP_W-1:0]   fmt_rep;
  logic [PAY_W-1:0]   fmt_pay;
  logic [CAS_W-1:0]   cas_sel;
  logic [REF_W-1:0]   ref_sel;

  sdinit_bank_pick #(.NB(NB)) u_pick (
    .pend      (pend_q),
    .any       (pick_any),
    .idx       (pick_idx),
    .pend_next (pick_next)
  );

  sdinit_timer #(.W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tmr_load),
    .tick     (tmr_tick),
    .load_val (fmt_wait),
    .zero     (tmr_zero)
  );

  sdinit_cmd_fmt #(
    .CAS_W     (CAS_W),
    .PAY_W     (PAY_W),
    .REP_W     (REP_W),
    .WAIT_W    (WAIT_W),
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC)
  ) u_fmt (
    .step     (step_q),
    .cas      (cas_sel),
    .mode     (fmt_mode),
    .rep      (fmt_rep),
    .payload  (fmt_pay),
    .wait_cyc (fmt_wait)
  );

  assign cas_sel = cas_lat[int'(bank_q)*CAS_W +: CAS_W];
  assign ref_sel = refresh_cnt[int'(bank_q)*REF_W +: REF_W];

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    bank_d   = bank_q;
    pend_d   = pend_q;
    en_d     = en_q;
    tmr_load = 1'b0;
    tmr_tick = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          pend_d  = bank_en;
          en_d    = 1'b0;
          state_d = ST_PICK;
        end
      end
      ST_PICK: begin
        if (pick_any) begin
          bank_d  = pick_idx;
          pend_d  = pick_next;
          step_d  = STEP_CLKON;
          state_d = ST_ISSUE;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_ISSUE: begin
        tmr_load = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (tmr_zero) begin
          state_d = ST_POLL;
        end else begin
          tmr_tick = 1'b1;
        end
      end
      ST_POLL: begin
        if (!cmd_busy) begin
          if (step_q == STEP_NORM) begin
            state_d = ST_RTMR;
          end else begin
            step_d  = step_t'(step_q + 3'd1);
            state_d = ST_ISSUE;
          end
        end
      end
      ST_RTMR: begin
        state_d = ST_PICK;
      end
      ST_DONE: begin
        en_d    = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      step_q  <= STEP_CLKON;
      bank_q  <= '0;
      pend_q  <= '0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      bank_q  <= bank_d;
      pend_q  <= pend_d;
      en_q    <= en_d;
    end
  end

  // Outputs
  always_comb begin
    cmd_valid   = (state_q == ST_ISSUE);
    cmd_mode    = cmd_valid ? fmt_mode : MODE_NORMAL;
    cmd_target  = cmd_valid ? (2'b01 << bank_q) : 2'b00;
    cmd_repeat  = cmd_valid ? fmt_rep : '0;
    cmd_payload = cmd_valid ? fmt_pay : '0;
    rtimer_wr   = (state_q == ST_RTMR);
    rtimer_data = rtimer_wr ? {ref_sel, 1'b0} : '0;
    done        = (state_q == ST_DONE);
    ctrl_en     = en_q;
  end

endmodule

// File: rtl/sdinit_seq_chk.sv
module sdinit_seq_chk #(
  parameter int REF_W = 14,
  parameter int REP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_mode,
  input logic [1:0]       cmd_target,
  input logic [REP_W-1:0] cmd_repeat,
  input logic             rtimer_wr,
  input logic [REF_W:0]   rtimer_data,
  input logic             done,
  input logic             ctrl_en
);

  p_enable_low_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !ctrl_en);

  p_target_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($countones(cmd_target) == 1));

  p_single_cycle_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_aref_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_mode == 3'd3)) |-> (cmd_repeat == REP_W'(7)));

  p_rtimer_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rtimer_wr |-> (!rtimer_data[0] && !cmd_valid));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ctrl_en));

  p_done_enable_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctrl_en);

endmodule

bind sdinit_seq sdinit_seq_chk #(
  .REF_W (REF_W),
  .REP_W (REP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_mode    (cmd_mode),
  .cmd_target  (cmd_target),
  .cmd_repeat  (cmd_repeat),
  .rtimer_wr   (rtimer_wr),
  .rtimer_data (rtimer_data),
  .done        (done),
  .ctrl_en     (ctrl_en)
);

// File: tb/sdinit_seq_tb.sv
`timescale 1ns/1ps
module sdinit_seq_tb;

  localparam int CPU       = 2;
  localparam int LONG_US   = 200;
  localparam int SHORT_US  = 100;
  localparam int CAS_W     = 2;
  localparam int REF_W     = 14;
  localparam int PAY_W     = 13;
  localparam int REP_W     = 4;
  localparam int LONG_CYC  = CPU * LONG_US;
  localparam int SHORT_CYC = CPU * SHORT_US;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic [1:0]           bank_en = 2'b00;
  logic [2*CAS_W-1:0]   cas_lat = '0;
  logic [2*REF_W-1:0]   refresh_cnt = '0;
  logic                 cmd_busy;
  logic                 cmd_valid;
  logic [2:0]           cmd_mode;
  logic [1:0]           cmd_target;
  logic [REP_W-1:0]     cmd_repeat;
  logic [PAY_W-1:0]     cmd_payload;
  logic                 rtimer_wr;
  logic [REF_W:0]       rtimer_data;
  logic                 ctrl_en;
  logic                 done;

  always #4 clk = ~clk;

  sdinit_seq #(
    .CLK_PER_US (CPU),
    .LONG_US    (LONG_US),
    .SHORT_US   (SHORT_US),
    .CAS_W      (CAS_W),
    .REF_W      (REF_W),
    .PAY_W      (PAY_W),
    .REP_W      (REP_W)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .bank_en     (bank_en),
    .cas_lat     (cas_lat),
    .refresh_cnt (refresh_cnt),
    .cmd_busy    (cmd_busy),
    .cmd_valid   (cmd_valid),
    .cmd_mode    (cmd_mode),
    .cmd_target  (cmd_target),
    .cmd_repeat  (cmd_repeat),
    .cmd_payload (cmd_payload),
    .rtimer_wr   (rtimer_wr),
    .rtimer_data (rtimer_data),
    .ctrl_en     (ctrl_en),
    .done        (done)
  );

  // Issuer model: busy for busy_len cycles after each command
  int busy_len = 0;
  int busy_cnt = 0;
  assign cmd_busy = (busy_cnt != 0);
  always @(posedge clk) begin
    if (cmd_valid) busy_cnt <= busy_len;
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit mon_on = 1'b0;
  int idx, rt_count, done_count, nb, last_cyc;
  int bank_list [2];
  int cas_v [2];
  int ref_v [2];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Protocol monitor
  always @(negedge clk) begin
    int k, bi, b, em, er, ep, w;
    if (rst_n && mon_on) begin
      if (cmd_valid) begin
        k  = idx % 5;
        bi = idx / 5;
        b  = (bi < nb) ? bank_list[bi] : 0;
        chk(bi < nb, "R3", "command for a bank not enabled", bi, nb);
        em = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : (k == 3) ? 4 : 0;
        chk(cmd_mode == 3'(em), "R4", "command code", cmd_mode, em);
        chk(cmd_target == (2'b01 << b), "R3", "target", cmd_target, 1 << b);
        er = (k == 2) ? 7 : 0;
        chk(cmd_repeat == REP_W'(er), "R7", "repeat", cmd_repeat, er);
        ep = (k == 3) ? (cas_v[b] << 4) : 0;
        chk(cmd_payload == PAY_W'(ep), "R8", "payload", cmd_payload, ep);
        chk(!cmd_busy, "R6", "busy at issue", cmd_busy, 0);
        chk(!ctrl_en, "R2", "enable during run", ctrl_en, 0);
        if (k > 0) begin
          w = (k == 1) ? LONG_CYC : SHORT_CYC;
          chk((cyc - last_cyc) > w, "R5", "gap after previous command", cyc - last_cyc, w + 1);
        end else if (idx > 0) begin
          chk(rt_count == bi, "R9", "timer writes before next bank", rt_count, bi);
        end
        last_cyc = cyc;
        idx++;
      end
      if (rtimer_wr) begin
        bi = idx / 5 - 1;
        chk((idx % 5 == 0) && (idx > 0) && (rt_count == bi), "R9", "timer write position", idx, 5 * (rt_count + 1));
        if (bi >= 0 && bi < 2)
          chk(rtimer_data == (REF_W+1)'(ref_v[bank_list[bi]] << 1), "R9", "timer value",
              rtimer_data, ref_v[bank_list[bi]] << 1);
        chk(!cmd_busy, "R6", "busy at timer write", cmd_busy, 0);
        rt_count++;
      end
      if (done) begin
        chk(idx == 5 * nb, "R10", "commands before done", idx, 5 * nb);
        chk(rt_count == nb, "R10", "timer writes before done", rt_count, nb);
        chk(!ctrl_en, "R10", "enable still low at done", ctrl_en, 0);
        done_count++;
      end
    end
  end

  task automatic run(input logic [1:0] en, input int c0, input int c1,
                     input int r0, input int r1, input int b, input bit poke);
    int lat;
    bank_en     = en;
    cas_lat     = {c1[CAS_W-1:0], c0[CAS_W-1:0]};
    refresh_cnt = {r1[REF_W-1:0], r0[REF_W-1:0]};
    cas_v[0] = c0; cas_v[1] = c1;
    ref_v[0] = r0; ref_v[1] = r1;
    busy_len = b;
    nb = 0;
    for (int i = 0; i < 2; i++) begin
      if (en[i]) begin
        bank_list[nb] = i;
        nb++;
      end
    end
    idx = 0; rt_count = 0; done_count = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat = 1;
    chk(!ctrl_en, "R2", "enable cleared after start", ctrl_en, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      bank_en = ~en;
      start   = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    chk(done, "R10", "done seen", done, 1);
    if (nb == 0) chk(lat == 2, "R11", "done latency with no bank", lat, 2);
    @(negedge clk);
    chk(!done, "R10", "done lasts one cycle", done, 0);
    chk(ctrl_en, "R10", "enable high after done", ctrl_en, 1);
    chk(done_count == 1, "R2", "one done per run", done_count, 1);
    chk(idx == 5 * nb, "R2", "commands match captured enables", idx, 5 * nb);
    repeat (5) @(negedge clk);
    chk(ctrl_en && !cmd_valid && !rtimer_wr, "R10", "idle keeps enable", ctrl_en, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!ctrl_en && !done && !cmd_valid && !rtimer_wr, "R1", "outputs in reset", ctrl_en, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!ctrl_en && !done && !cmd_valid && !rtimer_wr, "R1", "outputs after reset", done, 0);
    mon_on = 1'b1;
    for (int e = 0; e < 4; e++) begin
      for (int s = 0; s < 3; s++) begin
        run(2'(e), (e + s) % 4, 3 - ((e + s) % 4), 8196, 100 + 37 * e + s,
            (s == 0) ? 0 : (s == 1) ? 3 : 250, 1'b0);
      end
    end
    run(2'b11, 1, 2, 8196, 4000, 5, 1'b1);
    run(2'b01, 3, 0, 1234, 8196, 250, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule